// File: doc/BRIEF.md
# Multichannel Pulse-Width and Rate-Multiplier DAC Generator

The block turns a 10-bit code per channel into a digital pulse train whose average high time, after external low-pass filtering, stands for that code. All channels run from one shared free-running 10-bit count. The lower six bits of the count set a short 64-clock pulse period. Each channel's six upper code bits set the pulse width inside that period. The four lower code bits add one extra clock of high time in a chosen subset of the sixteen periods that make up one full count cycle. This gives ten bits of resolution with a pulse repeat rate of only 64 clocks.

Software programs each channel through a synchronous write port. One write carries the channel's code and four control bits: enable, polarity invert, logic-output mode and logic level. A new code is held in a staging register and moves into service only when the full 10-bit count wraps, so no period is ever cut short. The control bits take effect at once. In logic-output mode the pin follows the level bit, which makes the channel a plain general-purpose output.

Top module: `pwm_brm_dac`

## Requirements
- R1: One 10-bit count shared by all channels advances by one on every clock after reset and wraps from 1023 to 0. Its low 6 bits are the in-period phase and its high 4 bits are the period index k (0..15).
- R2: A write with `wr_en` high loads channel `wr_ch`. In `wr_data`, bits [9:0] hold the code, bit 10 is enable, bit 11 is invert, bit 12 is logic-output mode and bit 13 is the logic level. Within the code, bits [9:4] are the pulse width D and bits [3:0] are the rate-multiplier field B. A `wr_ch` value of NUM_CH or above writes nothing.
- R3: For an enabled, non-inverted channel in normal mode, the pin sampled after the clock edge that used count value c is high exactly when phase(c) < D + e(k). A channel with D = 0 and e = 0 stays low for the whole period.
- R4: The extra clock e(k) is taken from B as follows: B[3] applies when k is odd, B[2] when k mod 4 = 2, B[1] when k mod 8 = 4, and B[0] when k = 8. At most one of these positions applies in any period, and there is none when k = 0.
- R5: With a steady configuration, the number of high samples in any 1024 consecutive clocks equals the code for a non-inverted enabled channel, and equals 1024 minus the code when the channel is inverted.
- R6: The invert bit XORs the pin in every mode.
- R7: A disabled channel in normal mode drives its inactive level, which is the invert bit.
- R8: In logic-output mode the pin equals level XOR invert, whatever the code and the enable bit are.
- R9: A written code goes into service at the next wrap of the count from 1023 to 0. A channel keeps producing its previous code until then. A written control bit shows on the pin two clocks after the write is presented.
- R10: While reset is asserted, and after reset until the first write, every pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the shared count advances on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| wr_en | input | 1 | Write strobe for the channel setting |
| wr_ch | input | CH_W (2) | Channel index for the write |
| wr_data | input | VAL_W+4 (14) | Code and control bits, laid out as in R2 |
| pin | output | NUM_CH (4) | Registered pulse outputs, one per channel |

## Verification
On every cycle the assertions check several things: the count steps by one, at most one rate-multiplier position is selected, the in-service code changes only at a count wrap, a zero code keeps the pin low, and a disabled channel or a channel in logic mode drives the level its control bits imply. Only the bench scenarios can show the exact shape of each pulse across a whole 1024-clock cycle, the total high time matching the code for every pulse width, the hand-over from old to new code at the wrap, and the two-clock delay of the control bits. The bench locks onto the count phase using a marker channel that emits one pulse per cycle. It then compares every channel sample by sample against an arithmetic model.

// File: rtl/pwm_brm_pkg.sv
package pwm_brm_pkg;

  // Per-channel control bits; member order matches wr_data[VAL_W+3:VAL_W]
  typedef struct packed {
    logic lvl;   // level driven in logic-output mode
    logic mode;  // 1: logic-output mode
    logic inv;   // polarity invert
    logic en;    // channel enable
  } chan_ctl_t;

  localparam int CTL_W = 4;

endpackage

// File: rtl/pwm_brm_rstsync.sv
module pwm_brm_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;

endmodule

// File: rtl/pwm_brm_timebase.sv
module pwm_brm_timebase #(
  parameter int PWM_W = 6,
  parameter int BRM_W = 4,
  localparam int CNT_W = PWM_W + BRM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic [BRM_W-1:0] brm_sel,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [BRM_W-1:0] period;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign period = cnt_q[CNT_W-1:PWM_W];
  assign wrap   = (cnt_q == {CNT_W{1'b1}});
  assign cnt    = cnt_q;

  // Field bit j (weight 2^j) is selected in 2^j of the 2^BRM_W periods,
  // those whose index has exactly BRM_W-1-j trailing zeros.
  for (genvar j = 0; j < BRM_W; j++) begin : g_sel
    localparam int LEN = BRM_W - j;
    assign brm_sel[j] = (period[LEN-1:0] == LEN'(1 << (LEN - 1)));
  end

endmodule

// File: rtl/pwm_brm_regs.sv
module pwm_brm_regs
  import pwm_brm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int VAL_W  = 10,
  parameter int CH_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [CH_W-1:0]              wr_ch,
  input  logic [VAL_W+CTL_W-1:0]       wr_data,
  input  logic                         wrap,
  output logic [NUM_CH-1:0][VAL_W-1:0] act_val,
  output chan_ctl_t [NUM_CH-1:0]       ctl
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             hit;
    logic [VAL_W-1:0] stage_q, stage_d;
    logic [VAL_W-1:0] act_q, act_d;
    chan_ctl_t        ctl_q, ctl_d;

    always_comb begin
      hit     = wr_en && (wr_ch == CH_W'(g));
      stage_d = hit ? wr_data[VAL_W-1:0] : stage_q;
      ctl_d   = hit ? chan_ctl_t'(wr_data[VAL_W +: CTL_W]) : ctl_q;
      act_d   = wrap ? stage_q : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        act_q   <= '0;
        ctl_q   <= '0;
      end else begin
        stage_q <= stage_d;
        act_q   <= act_d;
        ctl_q   <= ctl_d;
      end
    end

    assign act_val[g] = act_q;
    assign ctl[g]     = ctl_q;
  end

endmodule

// File: rtl/pwm_brm_chan.sv
module pwm_brm_chan
  import pwm_brm_pkg::*;
#(
  parameter int PWM_W = 6,
  parameter int BRM_W = 4,
  localparam int VAL_W = PWM_W + BRM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PWM_W-1:0] pwm_ph,
  input  logic [BRM_W-1:0] brm_sel,
  input  logic [VAL_W-1:0] value,
  input  chan_ctl_t        ctl,
  output logic             pin
);

  logic [PWM_W-1:0] duty;
  logic             extra;
  logic [PWM_W:0]   limit;
  logic             raw;
  logic             lvl_pre;
  logic             pin_d;
  logic             pin_q;

  always_comb begin
    duty    = value[VAL_W-1:BRM_W];
    extra   = |(brm_sel & value[BRM_W-1:0]);
    limit   = {1'b0, duty} + {{PWM_W{1'b0}}, extra};
    raw     = ({1'b0, pwm_ph} < limit);
    lvl_pre = ctl.mode ? ctl.lvl : (ctl.en & raw);
    pin_d   = lvl_pre ^ ctl.inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign pin = pin_q;

endmodule

// File: rtl/pwm_brm_dac.sv
module pwm_brm_dac
  import pwm_brm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PWM_W  = 6,
  parameter int BRM_W  = 4,
  localparam int VAL_W  = PWM_W + BRM_W,
  localparam int CNT_W  = PWM_W + BRM_W,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DATA_W = VAL_W + CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] pin
);

  logic                         rst_sync_n;
  logic [CNT_W-1:0]             cnt;
  logic [BRM_W-1:0]             brm_sel;
  logic                         wrap;
  logic [NUM_CH-1:0][VAL_W-1:0] act_val;
  chan_ctl_t [NUM_CH-1:0]       ctl;

  pwm_brm_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_brm_timebase #(.PWM_W(PWM_W), .BRM_W(BRM_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cnt     (cnt),
    .brm_sel (brm_sel),
    .wrap    (wrap)
  );

  pwm_brm_regs #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .CH_W(CH_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_data (wr_data),
    .wrap    (wrap),
    .act_val (act_val),
    .ctl     (ctl)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    pwm_brm_chan #(.PWM_W(PWM_W), .BRM_W(BRM_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pwm_ph  (cnt[PWM_W-1:0]),
      .brm_sel (brm_sel),
      .value   (act_val[g]),
      .ctl     (ctl[g]),
      .pin     (pin[g])
    );
  end

endmodule

// File: rtl/pwm_brm_dac_chk.sv
module pwm_brm_dac_chk
  import pwm_brm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PWM_W  = 6,
  parameter int BRM_W  = 4,
  localparam int VAL_W = PWM_W + BRM_W,
  localparam int CNT_W = PWM_W + BRM_W
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [CNT_W-1:0]             cnt,
  input logic [BRM_W-1:0]             brm_sel,
  input logic [NUM_CH-1:0][VAL_W-1:0] act_val,
  input chan_ctl_t [NUM_CH-1:0]       ctl,
  input logic [NUM_CH-1:0]            pin
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt == CNT_W'($past(cnt) + 1'b1)); // R1

  AST_BRM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(brm_sel)); // R4

  AST_CODE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cnt != '0) |-> $stable(act_val)); // R9

  for (genvar g = 0; g < NUM_CH; g++) begin : g_pin
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(act_val[g] == '0 && ctl[g].en && !ctl[g].inv && !ctl[g].mode))
      |-> !pin[g]); // R3

    AST_DISABLED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!ctl[g].en && !ctl[g].mode))
      |-> pin[g] == $past(ctl[g].inv)); // R7

    AST_LOGIC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctl[g].mode))
      |-> pin[g] == $past(ctl[g].lvl ^ ctl[g].inv)); // R8
  end

endmodule

bind pwm_brm_dac pwm_brm_dac_chk #(
  .NUM_CH (NUM_CH),
  .PWM_W  (PWM_W),
  .BRM_W  (BRM_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .cnt     (cnt),
  .brm_sel (brm_sel),
  .act_val (act_val),
  .ctl     (ctl),
  .pin     (pin)
);

// File: tb/pwm_brm_dac_test.sv
module pwm_brm_dac_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic [13:0] wr_data = '0;
  logic [3:0]  pin;

  always #4 clk = ~clk;  // 125 MHz

  pwm_brm_dac #(.NUM_CH(4), .PWM_W(6), .BRM_W(4)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_data (wr_data),
    .pin     (pin)
  );

  int errs = 0;
  int checks = 0;
  int phase = 0;
  int cyc = 0;
  int mv[4];
  bit men[4], minv[4], mmode[4], mlvl[4];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errs++;
      checks++;
      $display("FAIL R1 watchdog: actual=%0d cycles expected=fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    phase = (phase + 1) % 1024;
  endtask

  // R2 layout: {lvl, mode, inv, en, code[9:0]}
  task automatic wr(int ch, int v, bit en, bit inv, bit mode, bit lvl);
    wr_en   = 1'b1;
    wr_ch   = ch[1:0];
    wr_data = {lvl, mode, inv, en, v[9:0]};
    step();
    wr_en   = 1'b0;
  endtask

  task automatic set_model(int ch, int v, bit en, bit inv, bit mode, bit lvl);
    mv[ch] = v; men[ch] = en; minv[ch] = inv; mmode[ch] = mode; mlvl[ch] = lvl;
  endtask

  // Expected pin for count value p (R3, R4, R6, R7, R8)
  function automatic bit model(int p, int v, bit en, bit inv, bit mode, bit lvl);
    int k, ph, d, b, e, t;
    bit raw;
    k = p / 64; ph = p % 64; d = v / 16; b = v % 16; e = 0;
    if (k != 0) begin
      t = 0;
      while (((k >> t) & 1) == 0) t++;
      e = (b >> (3 - t)) & 1;
    end
    raw = (ph < d + e);
    return (mode ? lvl : (en && raw)) ^ inv;
  endfunction

  function automatic int exp_high(int ch);
    int base;
    base = mmode[ch] ? (mlvl[ch] ? 1024 : 0) : (men[ch] ? mv[ch] : 0);
    return minv[ch] ? 1024 - base : base;
  endfunction

  function automatic string req_of(int ch);
    if (mmode[ch]) return "R8";
    if (!men[ch]) return "R7";
    if (minv[ch]) return "R6";
    return "R3";
  endfunction

  // Full cycle compare; call with phase == 1023
  task automatic window();
    int mism[4];
    int high[4];
    for (int c = 0; c < 4; c++) begin mism[c] = 0; high[c] = 0; end
    for (int i = 0; i < 1024; i++) begin
      step();
      for (int c = 0; c < 4; c++) begin
        if (pin[c] !== model(phase, mv[c], men[c], minv[c], mmode[c], mlvl[c])) mism[c]++;
        if (pin[c] === 1'b1) high[c]++;
      end
    end
    for (int c = 0; c < 4; c++) begin
      check(mism[c] == 0, req_of(c), $sformatf("ch%0d code %0d sample mismatches", c, mv[c]), mism[c], 0);
      check(high[c] == exp_high(c), "R5", $sformatf("ch%0d code %0d high count", c, mv[c]), high[c], exp_high(c));
    end
  endtask

  task automatic goto(int p);
    while (phase != p) step();
  endtask

  initial begin
    int guard, mm1, mm3, bad;
    for (int c = 0; c < 4; c++) set_model(c, 0, 0, 0, 0, 0);

    repeat (5) @(negedge clk);
    check(pin === 4'b0000, "R10", "pins during reset", int'(pin), 0);
    rst_n = 1'b1;
    bad = 0;
    for (int i = 0; i < 1100; i++) begin
      step();
      if (pin !== 4'b0000) bad++;
    end
    check(bad == 0, "R10", "non-low samples before first write", bad, 0);

    // Marker: code 1 gives one pulse per cycle at count 512 (R4: B[0], k=8)
    wr(0, 1, 1, 0, 0, 0);
    set_model(0, 1, 1, 0, 0, 0);
    guard = 0;
    while (pin[0] !== 1'b1 && guard < 3000) begin step(); guard++; end
    check(guard < 3000, "R4", "marker pulse found", guard, 0);
    phase = 512;
    goto(1023);
    window();

    // R9: deferred code hand-over and two-clock control latency
    goto(100);
    wr(1, 16 * 5 + 3, 1, 0, 0, 0);
    wr(3, 512, 1, 0, 0, 0);
    set_model(1, 16 * 5 + 3, 1, 0, 0, 0);
    set_model(3, 512, 1, 0, 0, 0);
    goto(1023);
    window();
    goto(200);
    wr(1, 16 * 40 + 9, 1, 0, 0, 0);
    mm1 = 0; mm3 = 0;
    while (1) begin
      if (pin[1] !== model(phase, 16 * 5 + 3, 1, 0, 0, 0)) mm1++;
      if (pin[3] !== model(phase, 512, 1, (phase >= 302), 0, 0)) mm3++;
      if (phase == 1023) break;
      if (phase == 300) wr(3, 512, 1, 1, 0, 0);
      else step();
    end
    check(mm1 == 0, "R9", "old code held until wrap", mm1, 0);
    check(mm3 == 0, "R9", "control bit two-clock latency", mm3, 0);
    set_model(1, 16 * 40 + 9, 1, 0, 0, 0);
    set_model(3, 512, 1, 1, 0, 0);
    window();

    // Sweep all pulse widths with rotating rate fields and modes
    for (int r = 0; r < 64; r++) begin
      int v1, v2, v3, sel;
      bit e3, i3, m3, l3;
      v1 = (r << 4) | (r & 15);
      v2 = 1023 - v1;
      v3 = (r * 37) % 1024;
      sel = r % 4;
      e3 = (sel == 0) || (sel == 3) || (sel == 2 && r[4]);
      i3 = (sel == 3) || (sel == 1 && r[2]) || (sel == 2 && r[3]);
      m3 = (sel == 2);
      l3 = r[2];
      goto(100);
      wr(1, v1, 1, 0, 0, 0);
      wr(2, v2, 1, r[0], 0, 0);
      wr(3, v3, e3, i3, m3, l3);
      set_model(1, v1, 1, 0, 0, 0);
      set_model(2, v2, 1, r[0], 0, 0);
      set_model(3, v3, e3, i3, m3, l3);
      goto(1023);
      window();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule